// File: doc/BRIEF.md
# Cache Array Access Port

This block lets software load and store the internal state of a 4-way set-associative cache with 16-byte lines. Two windows of the 32-bit address space, chosen by the top address byte, are decoded. The 0xF1 window reaches the longwords of the data store. The 0xF0 window reaches the per-entry tag, valid bit, dirty bit and replacement (LRU) field. Each access names an entry index, a way and, for data, a longword within the line. The entry index has 128 values per way.

Tag writes come in two kinds. A direct write replaces the whole entry in the addressed way. An associative write compares the supplied tag against every valid way of the indexed entry. On a hit it changes only the valid and dirty bits. If that write invalidates a dirty line, the block raises a write-back request. The request stays asserted until the request is acknowledged. While the request is outstanding, the bus stalls. Refill, normal lookup and the memory interface are not part of this block.

Top module: `cache_array_port`

## Requirements
- R1: An accepted read of the data window returns a longword one cycle later with `rsp_valid` high. The data window is address bits [31:24] = 0xF1. The longword is the one selected by way W = address bits [12:11] (00 to 11 meaning ways 0 to 3), entry index = bits [10:4], and longword L = bits [3:2] (00 to 11 meaning longwords 0 to 3).
- R2: An accepted write of the data window stores `req_wdata` at that longword. Data-window reads and writes leave every tag, valid, dirty and LRU value unchanged.
- R3: Some accesses are ignored. These are accesses with address bits [1:0] not 00, and accesses whose top byte is neither 0xF1 nor 0xF0. Writes of this kind change nothing, and reads of this kind return 0 one cycle later.
- R4: A direct tag write uses the 0xF0 window with address bit 3 = 0. It sets the addressed way's entry: tag from `req_wdata[31:11]`, LRU from [9:4], dirty from [1] and valid from [0]. A tag read returns the same layout, with zeros in bits 10, 3 and 2.
- R5: Any tag write that writes the valid bit as 0 also clears the dirty bit of that entry.
- R6: An associative tag write uses the 0xF0 window with address bit 3 = 1. It ignores the way field and compares `req_wdata[31:11]` against the tags of the valid ways at the index. When no way matches, nothing changes.
- R7: On an associative hit, only the valid and dirty bits of the hit way are written. The tag and LRU of that way are kept.
- R8: An associative hit can write valid = 0 to an entry that was dirty. In the cycle after that write, `wb_valid` rises, with `wb_way`, `wb_index` and `wb_tag` naming the line. These outputs hold steady until `wb_ack` is seen, and `wb_valid` falls the cycle after. Invalidating a clean line raises no request.
- R9: While `wb_valid` is high, `req_ready` is low and no access is accepted. A request held through the stall is accepted once the request is acknowledged.
- R10: After reset, `req_ready` is high and `rsp_valid` and `wb_valid` are low. Every entry reads back with tag, LRU, valid and dirty all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Access address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| wb_valid | output | 1 | Write-back request pending |
| wb_way | output | 2 | Way of the line to write back |
| wb_index | output | 7 | Entry index of the line to write back |
| wb_tag | output | 21 | Tag of the line to write back |
| wb_ack | input | 1 | Write-back request acknowledge |

## Verification
Read data and `rsp_valid` arrive on the first rising edge after the edge that accepts the read. State written by a store is visible to a read accepted on the next edge. `wb_valid` rises one edge after the invalidating write and falls one edge after the edge that sees `wb_ack`. The bench drives inputs on falling edges. After each rising edge it advances its own model of the arrays and the pending request, and it compares every output on the following falling edge. Response data is thus checked exactly in the cycle it becomes due. Stalls are checked by holding a request across the pending window and confirming that the model and the port agree on the cycle of acceptance.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_TAG  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/cap_decode.sv
module cap_decode
  import cap_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              WIN_W    = 8,
  parameter logic [WIN_W-1:0] DATA_WIN = 8'hF1,
  parameter logic [WIN_W-1:0] TAG_WIN  = 8'hF0,
  parameter int              WRD_W    = 2,
  parameter int              IDX_W    = 7,
  parameter int              WAY_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  idx,
  output logic [WAY_W-1:0]  way,
  output logic [WRD_W-1:0]  word,
  output logic              assoc
);
  localparam int WRD_LSB = 2;
  localparam int IDX_LSB = WRD_LSB + WRD_W;
  localparam int WAY_LSB = IDX_LSB + IDX_W;
  localparam int WIN_LSB = ADDR_W - WIN_W;

  logic              aligned;
  logic [WIN_W-1:0]  win;
  logic              unused_mid;

  assign aligned    = (addr[WRD_LSB-1:0] == '0);
  assign win        = addr[ADDR_W-1:WIN_LSB];
  assign word       = addr[IDX_LSB-1:WRD_LSB];
  assign idx        = addr[WAY_LSB-1:IDX_LSB];
  assign way        = addr[WAY_LSB+WAY_W-1:WAY_LSB];
  assign assoc      = addr[IDX_LSB-1];
  assign unused_mid = ^addr[WIN_LSB-1:WAY_LSB+WAY_W];

  always_comb begin
    kind = ACC_NONE;
    if (aligned && (win == DATA_WIN))     kind = ACC_DATA;
    else if (aligned && (win == TAG_WIN)) kind = ACC_TAG;
  end
endmodule

// File: rtl/cap_data_store.sv
module cap_data_store #(
  parameter int DATA_W  = 32,
  parameter int WAYS    = 4,
  parameter int ENTRIES = 128,
  parameter int WORDS   = 4
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [$clog2(WAYS)-1:0]    way,
  input  logic [$clog2(ENTRIES)-1:0] idx,
  input  logic [$clog2(WORDS)-1:0]   word,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata
);
  logic [DATA_W-1:0] mem_q [WAYS][ENTRIES][WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[way][idx][word] <= wdata;
  end

  assign rdata = mem_q[way][idx][word];
endmodule

// File: rtl/cap_tag_store.sv
module cap_tag_store #(
  parameter int WAYS    = 4,
  parameter int ENTRIES = 128,
  parameter int TAG_W   = 21,
  parameter int LRU_W   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       assoc,
  input  logic [$clog2(ENTRIES)-1:0] idx,
  input  logic [$clog2(WAYS)-1:0]    way,
  input  logic [TAG_W-1:0]           wtag,
  input  logic [LRU_W-1:0]           wlru,
  input  logic                       wv,
  input  logic                       wu,
  output logic [TAG_W-1:0]           rd_tag,
  output logic [LRU_W-1:0]           rd_lru,
  output logic                       rd_v,
  output logic                       rd_u,
  output logic                       wb_fire,
  output logic [$clog2(WAYS)-1:0]    wb_way,
  output logic [TAG_W-1:0]           wb_tag
);
  localparam int WAY_W = $clog2(WAYS);

  logic [TAG_W-1:0] tag_q [WAYS][ENTRIES];
  logic [LRU_W-1:0] lru_q [WAYS][ENTRIES];
  logic             v_q   [WAYS][ENTRIES];
  logic             u_q   [WAYS][ENTRIES];

  logic [WAYS-1:0]  match, hit_sel, dir_we, asc_we;
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic             new_u;

  // next-state: strobes and values
  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      match[w] = v_q[w][idx] && (tag_q[w][idx] == wtag);
    for (int w = WAYS-1; w >= 0; w--) begin
      if (match[w]) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      hit_sel[w] = hit && (hit_way == WAY_W'(w));
      dir_we[w]  = wr_en && !assoc && (way == WAY_W'(w));
      asc_we[w]  = wr_en && assoc && hit_sel[w];
    end
    new_u   = wv & wu;
    wb_fire = wr_en && assoc && hit && !wv && u_q[hit_way][idx];
    wb_way  = hit_way;
    wb_tag  = tag_q[hit_way][idx];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) begin
        for (int e = 0; e < ENTRIES; e++) begin
          tag_q[w][e] <= '0;
          lru_q[w][e] <= '0;
          v_q[w][e]   <= 1'b0;
          u_q[w][e]   <= 1'b0;
        end
      end
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        if (dir_we[w]) begin
          tag_q[w][idx] <= wtag;
          lru_q[w][idx] <= wlru;
          v_q[w][idx]   <= wv;
          u_q[w][idx]   <= new_u;
        end else if (asc_we[w]) begin
          v_q[w][idx]   <= wv;
          u_q[w][idx]   <= new_u;
        end
      end
    end
  end

  assign rd_tag = tag_q[way][idx];
  assign rd_lru = lru_q[way][idx];
  assign rd_v   = v_q[way][idx];
  assign rd_u   = u_q[way][idx];

  // R5: an invalid entry never holds a dirty mark
  for (genvar g = 0; g < WAYS; g++) begin : g_chk
    a_r5_clean_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      !v_q[g][idx] |-> !u_q[g][idx]);
  end
endmodule

// File: rtl/cap_wb_ctrl.sv
module cap_wb_ctrl #(
  parameter int WAY_W = 2,
  parameter int IDX_W = 7,
  parameter int TAG_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [WAY_W-1:0] in_way,
  input  logic [IDX_W-1:0] in_idx,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             ack,
  output logic             valid,
  output logic [WAY_W-1:0] way,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  logic valid_d;
  logic load;

  always_comb begin
    load    = fire;
    valid_d = valid;
    if (fire)             valid_d = 1'b1;
    else if (valid && ack) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      way   <= '0;
      idx   <= '0;
      tag   <= '0;
    end else begin
      valid <= valid_d;
      if (load) begin
        way <= in_way;
        idx <= in_idx;
        tag <= in_tag;
      end
    end
  end

  // R8: request fields hold until acknowledged
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ack |=> valid && $stable(way) && $stable(idx) && $stable(tag));
  // R8: acknowledge retires the request
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ack |=> !valid);
endmodule

// File: rtl/cache_array_port.sv
module cache_array_port
  import cap_pkg::*;
#(
  parameter int         DATA_W   = 32,
  parameter int         WAYS     = 4,
  parameter int         ENTRIES  = 128,
  parameter int         WORDS    = 4,
  parameter int         LRU_W    = 6,
  parameter logic [7:0] DATA_WIN = 8'hF1,
  parameter logic [7:0] TAG_WIN  = 8'hF0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic                            req_we,
  input  logic [DATA_W-1:0]               req_addr,
  input  logic [DATA_W-1:0]               req_wdata,
  output logic                            req_ready,
  output logic                            rsp_valid,
  output logic [DATA_W-1:0]               rsp_rdata,
  output logic                            wb_valid,
  output logic [$clog2(WAYS)-1:0]         wb_way,
  output logic [$clog2(ENTRIES)-1:0]      wb_index,
  output logic [DATA_W-2-$clog2(WORDS)-$clog2(ENTRIES)-1:0] wb_tag,
  input  logic                            wb_ack
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int WRD_W = $clog2(WORDS);
  localparam int TAG_W = DATA_W - 2 - WRD_W - IDX_W;
  localparam int PAD_W = DATA_W - TAG_W - LRU_W - 4;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  acc_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic [WAY_W-1:0] way;
  logic [WRD_W-1:0] word;
  logic             assoc;

  cap_decode #(
    .ADDR_W(DATA_W), .WIN_W(8), .DATA_WIN(DATA_WIN), .TAG_WIN(TAG_WIN),
    .WRD_W(WRD_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_decode (
    .addr(req_addr), .kind(kind), .idx(idx), .way(way), .word(word), .assoc(assoc)
  );

  logic accept, data_we, tag_we, rd_acc;
  assign req_ready = !wb_valid;
  assign accept    = req_valid && req_ready;
  assign data_we   = accept && req_we && (kind == ACC_DATA);
  assign tag_we    = accept && req_we && (kind == ACC_TAG);
  assign rd_acc    = accept && !req_we;

  logic [DATA_W-1:0] data_rd;
  cap_data_store #(
    .DATA_W(DATA_W), .WAYS(WAYS), .ENTRIES(ENTRIES), .WORDS(WORDS)
  ) u_data (
    .clk(clk), .wr_en(data_we), .way(way), .idx(idx), .word(word),
    .wdata(req_wdata), .rdata(data_rd)
  );

  logic [TAG_W-1:0] rd_tag, fire_tag;
  logic [LRU_W-1:0] rd_lru;
  logic             rd_v, rd_u, fire;
  logic [WAY_W-1:0] fire_way;
  logic             unused_wbits;

  assign unused_wbits = ^{req_wdata[DATA_W-TAG_W-1:LRU_W+4], req_wdata[3:2]};

  cap_tag_store #(
    .WAYS(WAYS), .ENTRIES(ENTRIES), .TAG_W(TAG_W), .LRU_W(LRU_W)
  ) u_tag (
    .clk(clk), .rst_n(rst_n_s), .wr_en(tag_we), .assoc(assoc), .idx(idx), .way(way),
    .wtag(req_wdata[DATA_W-1:DATA_W-TAG_W]), .wlru(req_wdata[LRU_W+3:4]),
    .wv(req_wdata[0]), .wu(req_wdata[1]),
    .rd_tag(rd_tag), .rd_lru(rd_lru), .rd_v(rd_v), .rd_u(rd_u),
    .wb_fire(fire), .wb_way(fire_way), .wb_tag(fire_tag)
  );

  cap_wb_ctrl #(
    .WAY_W(WAY_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_wb (
    .clk(clk), .rst_n(rst_n_s), .fire(fire), .in_way(fire_way), .in_idx(idx),
    .in_tag(fire_tag), .ack(wb_ack),
    .valid(wb_valid), .way(wb_way), .idx(wb_index), .tag(wb_tag)
  );

  // read response: next-state then register with clock enable
  logic [DATA_W-1:0] rsp_d;
  always_comb begin
    case (kind)
      ACC_DATA: rsp_d = data_rd;
      ACC_TAG:  rsp_d = {rd_tag, {PAD_W{1'b0}}, rd_lru, 2'b00, rd_u, rd_v};
      default:  rsp_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_rdata <= rsp_d;
    end
  end

  // R1: a response only follows an accepted read
  a_r1_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |-> $past(req_valid && req_ready && !req_we));
  // R9: nothing is accepted while a write-back is pending
  a_r9_no_rsp_when_stalled: assert property (@(posedge clk) disable iff (!rst_n_s)
    wb_valid && req_valid |=> !rsp_valid);
  // R8: a write-back request appears only after a tag write
  a_r8_rise_after_tag_write: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(wb_valid) |-> $past(req_valid && req_we && req_addr[31:24] == TAG_WIN));
endmodule

// File: tb/cache_array_port_tb.sv
module cache_array_port_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, req_we, wb_ack;
  logic [31:0] req_addr, req_wdata;
  logic        req_ready, rsp_valid, wb_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  wb_way;
  logic [6:0]  wb_index;
  logic [20:0] wb_tag;

  cache_array_port u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wb_valid(wb_valid),
    .wb_way(wb_way), .wb_index(wb_index), .wb_tag(wb_tag), .wb_ack(wb_ack)
  );

  int    checks = 0;
  int    fails  = 0;
  string cur    = "R10";

  // behavioural model
  logic [20:0] m_tag  [4][128];
  logic [5:0]  m_lru  [4][128];
  logic        m_v    [4][128];
  logic        m_u    [4][128];
  logic [31:0] m_data [4][128][4];
  logic        m_wbv, m_rv;
  logic [1:0]  m_wbw;
  logic [6:0]  m_wbi;
  logic [20:0] m_wbt;
  logic [31:0] m_rd;

  function automatic logic [31:0] da(int w, int i, int l);
    return {8'hF1, 11'd0, 2'(w), 7'(i), 2'(l), 2'b00};
  endfunction
  function automatic logic [31:0] ta(int w, int i, bit as);
    return {8'hF0, 11'd0, 2'(w), 7'(i), as, 3'b000};
  endfunction
  function automatic logic [31:0] tw(logic [20:0] t, logic [5:0] l, bit u, bit v);
    return {t, 1'b0, l, 2'b00, u, v};
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", cur, what, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("req_ready", 32'(req_ready), 32'(!m_wbv));
    chk("rsp_valid", 32'(rsp_valid), 32'(m_rv));
    if (m_rv) chk("rsp_rdata", rsp_rdata, m_rd);
    chk("wb_valid", 32'(wb_valid), 32'(m_wbv));
    if (m_wbv) begin
      chk("wb_way", 32'(wb_way), 32'(m_wbw));
      chk("wb_index", 32'(wb_index), 32'(m_wbi));
      chk("wb_tag", 32'(wb_tag), 32'(m_wbt));
    end
  endtask

  task automatic model(bit v, bit we, logic [31:0] a, logic [31:0] d, bit ack);
    bit rdy = !m_wbv;
    logic [1:0] w = a[12:11];
    logic [6:0] i = a[10:4];
    logic [1:0] l = a[3:2];
    bit al = (a[1:0] == 2'b00);
    int hw = -1;
    m_rv = 1'b0;
    if (m_wbv && ack) m_wbv = 1'b0;
    if (v && rdy) begin
      if (a[31:24] == 8'hF1 && al) begin
        if (we) m_data[w][i][l] = d;
        else begin m_rv = 1'b1; m_rd = m_data[w][i][l]; end
      end else if (a[31:24] == 8'hF0 && al) begin
        if (we && a[3]) begin
          for (int k = 3; k >= 0; k--)
            if (m_v[k][i] && m_tag[k][i] == d[31:11]) hw = k;
          if (hw >= 0) begin
            if (!d[0] && m_u[hw][i]) begin
              m_wbv = 1'b1; m_wbw = 2'(hw); m_wbi = i; m_wbt = m_tag[hw][i];
            end
            m_v[hw][i] = d[0];
            m_u[hw][i] = d[0] & d[1];
          end
        end else if (we) begin
          m_tag[w][i] = d[31:11]; m_lru[w][i] = d[9:4];
          m_v[w][i] = d[0]; m_u[w][i] = d[0] & d[1];
        end else begin
          m_rv = 1'b1;
          m_rd = tw(m_tag[w][i], m_lru[w][i], m_u[w][i], m_v[w][i]);
        end
      end else if (!we) begin
        m_rv = 1'b1; m_rd = 32'd0;
      end
    end
  endtask

  task automatic step(bit v, bit we, logic [31:0] a, logic [31:0] d, bit ack);
    req_valid = v; req_we = we; req_addr = a; req_wdata = d; wb_ack = ack;
    @(posedge clk);
    model(v, we, a, d, ack);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d); step(1, 1, a, d, 0); endtask
  task automatic rd(logic [31:0] a);                 step(1, 0, a, 32'd0, 0); endtask
  task automatic idle();                             step(0, 0, 32'd0, 32'd0, 0); endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, run did not complete");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; wb_ack = 1'b0;
    for (int w = 0; w < 4; w++)
      for (int e = 0; e < 128; e++) begin
        m_tag[w][e] = '0; m_lru[w][e] = '0; m_v[w][e] = 1'b0; m_u[w][e] = 1'b0;
      end
    m_wbv = 1'b0; m_rv = 1'b0; m_rd = '0; m_wbw = '0; m_wbi = '0; m_wbt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state and cleared entries
    cur = "R10";
    idle(); idle(); idle();
    rd(ta(2, 5, 0)); rd(ta(0, 127, 0)); rd(ta(3, 9, 0));

    // R4: direct tag writes and read layout
    cur = "R4";
    wr(ta(1, 9, 0), tw(21'h12345, 6'h2A, 1, 1)); rd(ta(1, 9, 0));
    wr(ta(3, 9, 0), tw(21'h0ABCD, 6'h15, 0, 1)); rd(ta(3, 9, 0));
    wr(ta(0, 127, 0), tw(21'h1FFFFF, 6'h3F, 1, 1)); rd(ta(0, 127, 0));

    // R1: data writes then reads at distinct way, index, longword
    cur = "R1";
    wr(da(1, 9, 2), 32'hA5A5_0001);
    wr(da(2, 9, 2), 32'h5A5A_0002);
    wr(da(1, 9, 0), 32'h1234_5678);
    wr(da(3, 127, 3), 32'hFFFF_0000);
    rd(da(1, 9, 2)); rd(da(2, 9, 2)); rd(da(1, 9, 0)); rd(da(3, 127, 3));

    // R2: data traffic leaves tag entries alone
    cur = "R2";
    wr(da(1, 9, 1), 32'hCAFE_F00D);
    rd(ta(1, 9, 0)); rd(ta(3, 9, 0)); rd(da(1, 9, 1));

    // R3: misaligned and unmapped accesses are ignored
    cur = "R3";
    wr(da(1, 9, 2) | 32'd1, 32'hDEAD_BEEF); rd(da(1, 9, 2));
    rd(da(1, 9, 2) | 32'd2);
    wr(32'h1200_0000, 32'h0000_1111); rd(32'h1200_0000);
    wr(ta(2, 9, 0) | 32'd2, tw(21'h1, 6'h1, 1, 1)); rd(ta(2, 9, 0));

    // R5: writing invalid with dirty set stores a clean entry
    cur = "R5";
    wr(ta(2, 9, 0), tw(21'h00777, 6'h01, 1, 0)); rd(ta(2, 9, 0));

    // R6: associative miss, including a tag held by an invalid way
    cur = "R6";
    wr(ta(0, 9, 1), tw(21'h55555, 6'h00, 1, 0));
    wr(ta(0, 9, 1), tw(21'h00777, 6'h00, 1, 1));
    rd(ta(1, 9, 0)); rd(ta(2, 9, 0)); rd(ta(3, 9, 0));

    // R7: associative hit keeps tag and LRU
    cur = "R7";
    wr(ta(0, 9, 1), tw(21'h0ABCD, 6'h00, 1, 1)); rd(ta(3, 9, 0));

    // R8: clean invalidate raises nothing
    cur = "R8";
    wr(ta(2, 20, 0), tw(21'h00042, 6'h03, 0, 1));
    wr(ta(0, 20, 1), tw(21'h00042, 6'h00, 0, 0));
    rd(ta(2, 20, 0));
    // R8: dirty invalidate raises and holds a request
    wr(ta(2, 9, 1), tw(21'h12345, 6'h00, 1, 0));
    idle(); idle();

    // R9: a read held through the stall goes through after acknowledge
    cur = "R9";
    step(1, 0, ta(1, 9, 0), 32'd0, 0);
    step(1, 0, ta(1, 9, 0), 32'd0, 0);
    step(1, 0, ta(1, 9, 0), 32'd0, 1);
    step(1, 0, ta(1, 9, 0), 32'd0, 0);
    idle();

    // R8: second dirty line, acknowledged at once
    cur = "R8";
    wr(ta(1, 127, 1), tw(21'h1FFFFF, 6'h00, 0, 0));
    step(0, 0, 32'd0, 32'd0, 1);
    idle();
    rd(ta(0, 127, 0));
    idle();

    summary();
    $finish;
  end
endmodule